// File: doc/BRIEF.md
# Command-Response Buffer Control Register Block

This block is the host-visible register file that sits in front of a security coprocessor. The coprocessor is driven through a shared command-response buffer. Host software first claims locality 0 and wakes the coprocessor out of idle. It then places a command in the buffer, outside this block, and rings a start doorbell. The block passes that doorbell on to the backend engine as a one-cycle request that carries the command length. It holds the start bit until the backend reports completion. While a command is in flight, the host may ring a cancel doorbell, and the block forwards it to the backend.

Every control register acts on a write only when the written value is exactly one recognised command code. Any other value, and any write to a read-only or unmapped offset, is dropped. Reads are byte-addressable and little-endian. Each read returns its data one cycle after the request, from a registered output. The interface identification word and the buffer address and size words are fixed by parameters. A write narrower than 32 bits is presented on `wr_data` zero-extended at its exact byte address.

Top module: `crb_ctrl_regs`

## Requirements
- R1: After reset, these registers read as follows. Locality state (offset 0x00) reads 0x80, with bit 0 ORed in as described in R9. Locality status (0x0C) reads 0. Control status (0x44) reads 0. Start (0x4C) reads 0. The interface word (0x30) reads 0x0002_5811. Both `be_req` and `be_cancel` are low.
- R2: Writing exactly 1 to locality control (0x08) sets three flags. Granted is bit 0 of 0x0C. Assigned is bit 1 of 0x00. Been-seized, bit 1 of 0x0C, is cleared.
- R3: Writing exactly 2 to 0x08 clears the assigned flag and leaves granted unchanged. Writes of 4 (seize), 8 (clear establishment) or any other value change nothing.
- R4: Writing exactly 1 to the control request register (0x40) clears the idle bit, bit 1 of 0x44. Writing exactly 2 sets it. Any other value, or a write at a different byte address, is ignored.
- R5: Writing exactly 1 to start (0x4C) while bit 0 of 0x4C is clear sets that bit and gives a one-cycle `be_req` pulse in the cycle after the write. While the bit is already set, or for any other value, the write has no effect.
- R6: Writing exactly 1 to cancel (0x48) while the start bit is set gives a one-cycle `be_cancel` pulse in the cycle after the write. Otherwise the write produces no pulse.
- R7: A `be_done` pulse clears the start bit. If `be_err` is high together with it, the fatal bit (bit 0 of 0x44) is set and stays set until reset.
- R8: `be_cmd_len` equals min(`cmd_hdr_size`, min(`be_capacity`, BUF_SIZE)), as sampled at the start write.
- R9: A read at byte address a returns the 32-bit word at a with its two low bits cleared, shifted right by 8 × a[1:0]. Bit 0 of the locality state word reads as the inverse of `be_established`.
- R10: The command and response size words (0x58, 0x64) read BUF_SIZE. The command and response address-low words (0x5C, 0x68) read BUF_BASE, and the address-high word (0x60) reads 0. Writes to these, to any other read-only offset or to an unmapped offset are dropped, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_data | input | 32 | Host write value, zero-extended |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read byte address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | rd_data is valid |
| cmd_hdr_size | input | LEN_W | Size field taken from the command header |
| be_capacity | input | LEN_W | Backend buffer capacity |
| be_established | input | 1 | Backend establishment flag |
| be_req | output | 1 | One-cycle command request to the backend |
| be_cmd_len | output | LEN_W | Command length sent with be_req |
| be_cancel | output | 1 | One-cycle cancel to the backend |
| be_done | input | 1 | Backend completion pulse |
| be_err | input | 1 | Completion carries an error |

## Verification
Each command register is written with its exact code, with the other one-hot codes, with multi-bit values and at an offset next to the right one. This separates an exact-value decoder from a bit-tested one and from one that ignores the low address bits. The doorbells are tried both idle and busy, which shows whether start and cancel are gated by the in-flight bit. The length is checked with the header, the capacity and the buffer size each in turn being the smallest, so every branch of the minimum is exercised. Byte-offset reads at every lane of a fixed word check the shift direction and amount.

// File: rtl/crb_pkg.sv
`timescale 1ns/1ps
package crb_pkg;
  // register offsets (byte addresses)
  localparam int OFS_LOC_STATE = 'h00;
  localparam int OFS_LOC_CTRL  = 'h08;
  localparam int OFS_LOC_STS   = 'h0C;
  localparam int OFS_IFACE_LO  = 'h30;
  localparam int OFS_IFACE_HI  = 'h34;
  localparam int OFS_REQ       = 'h40;
  localparam int OFS_STATUS    = 'h44;
  localparam int OFS_CANCEL    = 'h48;
  localparam int OFS_START     = 'h4C;
  localparam int OFS_CMD_SIZE  = 'h58;
  localparam int OFS_CMD_ADDR  = 'h5C;
  localparam int OFS_ADDR_HI   = 'h60;
  localparam int OFS_RSP_SIZE  = 'h64;
  localparam int OFS_RSP_ADDR  = 'h68;

  // exact command codes
  localparam logic [31:0] LOC_ACQUIRE = 32'h1;
  localparam logic [31:0] LOC_RELEASE = 32'h2;
  localparam logic [31:0] LOC_SEIZE   = 32'h4;
  localparam logic [31:0] LOC_CLR_EST = 32'h8;
  localparam logic [31:0] REQ_READY   = 32'h1;
  localparam logic [31:0] REQ_IDLE    = 32'h2;
  localparam logic [31:0] DOORBELL    = 32'h1;

  // interface identification fields
  localparam logic [3:0] IF_KIND_ACTIVE = 4'h1;
  localparam logic [3:0] IF_REV_BUF     = 4'h1;
  localparam logic       IF_MULTI_LOC   = 1'b0;
  localparam logic       IF_FAST_IDLE   = 1'b0;
  localparam logic [1:0] IF_XFER_64     = 2'b11;
  localparam logic       IF_HAS_FIFO    = 1'b0;
  localparam logic       IF_HAS_BUF     = 1'b1;
  localparam logic [1:0] IF_SEL_BUF     = 2'b01;
  localparam logic [3:0] IF_REVISION    = 4'h0;

  function automatic logic [31:0] iface_word();
    logic [31:0] w;
    w        = '0;
    w[3:0]   = IF_KIND_ACTIVE;
    w[7:4]   = IF_REV_BUF;
    w[8]     = IF_MULTI_LOC;
    w[9]     = IF_FAST_IDLE;
    w[12:11] = IF_XFER_64;
    w[13]    = IF_HAS_FIFO;
    w[14]    = IF_HAS_BUF;
    w[18:17] = IF_SEL_BUF;
    w[27:24] = IF_REVISION;
    return w;
  endfunction

  typedef struct packed {
    logic assigned;
    logic granted;
    logic seized;
  } loc_flags_t;

  typedef struct packed {
    logic idle;
    logic fatal;
    logic start;
  } ctl_flags_t;
endpackage

// File: rtl/crb_loc_ctrl.sv
`timescale 1ns/1ps
module crb_loc_ctrl
  import crb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hit,
  input  logic [31:0] value,
  output loc_flags_t  flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (hit) begin
      case (value)
        LOC_ACQUIRE: begin
          flags.granted  <= 1'b1;
          flags.seized   <= 1'b0;
          flags.assigned <= 1'b1;
        end
        LOC_RELEASE: flags.assigned <= 1'b0;
        LOC_SEIZE:   flags <= flags;  // single locality: nothing to take over
        LOC_CLR_EST: flags <= flags;  // not available to locality 0
        default:     flags <= flags;
      endcase
    end
  end
endmodule

// File: rtl/crb_cmd_ctrl.sv
`timescale 1ns/1ps
module crb_cmd_ctrl
  import crb_pkg::*;
#(
  parameter int LEN_W    = 32,
  parameter int BUF_SIZE = 3968
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_hit,
  input  logic             start_hit,
  input  logic             cancel_hit,
  input  logic [31:0]      value,
  input  logic [LEN_W-1:0] hdr_size,
  input  logic [LEN_W-1:0] capacity,
  input  logic             done,
  input  logic             err,
  output ctl_flags_t       flags,
  output logic             req_pulse,
  output logic [LEN_W-1:0] req_len,
  output logic             cancel_pulse
);
  localparam logic [LEN_W-1:0] BUF_LEN = LEN_W'(BUF_SIZE);

  logic [LEN_W-1:0] usable;
  logic [LEN_W-1:0] clipped;
  logic             launch;

  always_comb begin
    usable  = (capacity < BUF_LEN) ? capacity : BUF_LEN;
    clipped = (hdr_size < usable) ? hdr_size : usable;
    launch  = start_hit && (value == DOORBELL) && !flags.start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags        <= '0;
      req_pulse    <= 1'b0;
      req_len      <= '0;
      cancel_pulse <= 1'b0;
    end else begin
      req_pulse    <= launch;
      cancel_pulse <= cancel_hit && (value == DOORBELL) && flags.start;
      if (launch) req_len <= clipped;
      if (req_hit) begin
        case (value)
          REQ_READY: flags.idle <= 1'b0;
          REQ_IDLE:  flags.idle <= 1'b1;
          default:   flags.idle <= flags.idle;
        endcase
      end
      if (done) begin
        flags.start <= 1'b0;
        if (err) flags.fatal <= 1'b1;
      end else if (launch) begin
        flags.start <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crb_rd_mux.sv
`timescale 1ns/1ps
module crb_rd_mux
  import crb_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          BUF_SIZE = 3968,
  parameter logic [31:0] BUF_BASE = 32'hFED4_0080
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  loc_flags_t        loc,
  input  ctl_flags_t        ctl,
  input  logic              established,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  localparam logic [31:0] IFACE = iface_word();
  localparam logic [31:0] SIZE_WORD = 32'(BUF_SIZE);

  logic [ADDR_W-1:0] word_addr;
  logic [31:0]       word;
  logic [4:0]        shamt;

  always_comb begin
    word_addr = {rd_addr[ADDR_W-1:2], 2'b00};
    shamt     = {rd_addr[1:0], 3'b000};
    word      = '0;
    case (word_addr)
      ADDR_W'(OFS_LOC_STATE): begin
        word[7] = 1'b1;
        word[1] = loc.assigned;
        word[0] = !established;
      end
      ADDR_W'(OFS_LOC_STS): begin
        word[0] = loc.granted;
        word[1] = loc.seized;
      end
      ADDR_W'(OFS_IFACE_LO): word = IFACE;
      ADDR_W'(OFS_IFACE_HI): word = '0;
      ADDR_W'(OFS_STATUS): begin
        word[0] = ctl.fatal;
        word[1] = ctl.idle;
      end
      ADDR_W'(OFS_START):    word[0] = ctl.start;
      ADDR_W'(OFS_CMD_SIZE): word = SIZE_WORD;
      ADDR_W'(OFS_RSP_SIZE): word = SIZE_WORD;
      ADDR_W'(OFS_CMD_ADDR): word = BUF_BASE;
      ADDR_W'(OFS_RSP_ADDR): word = BUF_BASE;
      ADDR_W'(OFS_ADDR_HI):  word = '0;
      default:               word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= word >> shamt;
    end
  end
endmodule

// File: rtl/crb_ctrl_regs.sv
`timescale 1ns/1ps
module crb_ctrl_regs
  import crb_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          LEN_W    = 32,
  parameter int          BUF_SIZE = 3968,
  parameter logic [31:0] BUF_BASE = 32'hFED4_0080
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic [LEN_W-1:0]  cmd_hdr_size,
  input  logic [LEN_W-1:0]  be_capacity,
  input  logic              be_established,
  output logic              be_req,
  output logic [LEN_W-1:0]  be_cmd_len,
  output logic              be_cancel,
  input  logic              be_done,
  input  logic              be_err
);
  loc_flags_t loc_flags;
  ctl_flags_t ctl_flags;
  logic       loc_hit, req_hit, start_hit, cancel_hit;
  logic       start_bit, fatal_bit;

  always_comb begin
    loc_hit    = wr_en && (wr_addr == ADDR_W'(OFS_LOC_CTRL));
    req_hit    = wr_en && (wr_addr == ADDR_W'(OFS_REQ));
    start_hit  = wr_en && (wr_addr == ADDR_W'(OFS_START));
    cancel_hit = wr_en && (wr_addr == ADDR_W'(OFS_CANCEL));
    start_bit  = ctl_flags.start;
    fatal_bit  = ctl_flags.fatal;
  end

  crb_loc_ctrl u_loc (
    .clk   (clk),
    .rst   (rst),
    .hit   (loc_hit),
    .value (wr_data),
    .flags (loc_flags)
  );

  crb_cmd_ctrl #(.LEN_W(LEN_W), .BUF_SIZE(BUF_SIZE)) u_cmd (
    .clk          (clk),
    .rst          (rst),
    .req_hit      (req_hit),
    .start_hit    (start_hit),
    .cancel_hit   (cancel_hit),
    .value        (wr_data),
    .hdr_size     (cmd_hdr_size),
    .capacity     (be_capacity),
    .done         (be_done),
    .err          (be_err),
    .flags        (ctl_flags),
    .req_pulse    (be_req),
    .req_len      (be_cmd_len),
    .cancel_pulse (be_cancel)
  );

  crb_rd_mux #(.ADDR_W(ADDR_W), .BUF_SIZE(BUF_SIZE), .BUF_BASE(BUF_BASE)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .loc         (loc_flags),
    .ctl         (ctl_flags),
    .established (be_established),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );
endmodule

// File: rtl/crb_ctrl_regs_chk.sv
`timescale 1ns/1ps
module crb_ctrl_regs_chk #(
  parameter int LEN_W    = 32,
  parameter int BUF_SIZE = 3968
)(
  input logic             clk,
  input logic             rst,
  input logic             start_bit,
  input logic             fatal_bit,
  input logic             be_req,
  input logic [LEN_W-1:0] be_cmd_len,
  input logic             be_cancel,
  input logic             be_done,
  input logic             be_err
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    be_req |=> !be_req);  // R5
  AST_REQ_WITH_START: assert property (@(posedge clk) disable iff (rst)
    be_req |-> start_bit);  // R5
  AST_CANCEL_BUSY_ONLY: assert property (@(posedge clk) disable iff (rst)
    be_cancel |-> $past(start_bit));  // R6
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (be_done && start_bit) |=> !start_bit);  // R7
  AST_ERR_IS_FATAL: assert property (@(posedge clk) disable iff (rst)
    (be_done && be_err) |=> fatal_bit);  // R7
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    fatal_bit |=> fatal_bit);  // R7
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    be_req |-> (be_cmd_len <= LEN_W'(BUF_SIZE)));  // R8
endmodule

bind crb_ctrl_regs crb_ctrl_regs_chk #(.LEN_W(LEN_W), .BUF_SIZE(BUF_SIZE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_bit  (start_bit),
  .fatal_bit  (fatal_bit),
  .be_req     (be_req),
  .be_cmd_len (be_cmd_len),
  .be_cancel  (be_cancel),
  .be_done    (be_done),
  .be_err     (be_err)
);

// File: tb/crb_ctrl_regs_tb.sv
`timescale 1ns/1ps
module crb_ctrl_regs_tb;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 32;
  localparam int NVEC   = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0]       rd_data;
  logic              rd_valid;
  logic [LEN_W-1:0]  cmd_hdr_size = '0;
  logic [LEN_W-1:0]  be_capacity = '0;
  logic              be_established = 1'b1;
  logic              be_req;
  logic [LEN_W-1:0]  be_cmd_len;
  logic              be_cancel;
  logic              be_done = 1'b0;
  logic              be_err = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  crb_ctrl_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .cmd_hdr_size(cmd_hdr_size), .be_capacity(be_capacity),
    .be_established(be_established), .be_req(be_req), .be_cmd_len(be_cmd_len),
    .be_cancel(be_cancel), .be_done(be_done), .be_err(be_err)
  );

  // {write addr, write data, read addr, expected read, requirement}
  localparam logic [83:0] VEC [NVEC] = '{
    {8'h08, 32'h1,   8'h00, 32'h82,      4'd2},   // R2 acquire -> assigned
    {8'hFC, 32'h0,   8'h0C, 32'h1,       4'd2},   // R2 granted, not seized
    {8'h08, 32'h4,   8'h00, 32'h82,      4'd3},   // R3 seize no-op
    {8'h08, 32'h8,   8'h00, 32'h82,      4'd3},   // R3 clear-est no-op
    {8'h08, 32'h3,   8'h00, 32'h82,      4'd3},   // R3 multi-bit ignored
    {8'h08, 32'h2,   8'h00, 32'h80,      4'd3},   // R3 release
    {8'h08, 32'h2,   8'h0C, 32'h1,       4'd3},   // R3 granted kept
    {8'h40, 32'h2,   8'h44, 32'h2,       4'd4},   // R4 go idle
    {8'h40, 32'h3,   8'h44, 32'h2,       4'd4},   // R4 bad code
    {8'h40, 32'h102, 8'h44, 32'h2,       4'd4},   // R4 extra high bit
    {8'h41, 32'h1,   8'h44, 32'h2,       4'd4},   // R4 wrong byte address
    {8'h40, 32'h1,   8'h44, 32'h0,       4'd4},   // R4 ready
    {8'h58, 32'h0,   8'h58, 32'hF80,     4'd10},  // R10
    {8'h64, 32'h0,   8'h64, 32'hF80,     4'd10},  // R10
    {8'h5C, 32'h0,   8'h5C, 32'hFED40080, 4'd10}, // R10
    {8'h68, 32'h0,   8'h68, 32'hFED40080, 4'd10}, // R10
    {8'h30, 32'h0,   8'h30, 32'h25811,   4'd10},  // R10
    {8'h90, 32'h5,   8'h90, 32'h0,       4'd10},  // R10 unmapped
    {8'h60, 32'h7,   8'h60, 32'h0,       4'd10},  // R10 address high
    {8'h00, 32'hFF,  8'h00, 32'h80,      4'd10}   // R10 state is read-only
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic finish_cmd(input logic e);
    be_done = 1'b1; be_err = e;
    @(negedge clk);
    be_done = 1'b0; be_err = 1'b0;
  endtask

  task automatic reset_dut();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    @(negedge clk);
    reset_dut();

    // R1 reset values
    be_established = 1'b0;
    do_rd(8'h00, d); check("R1", "loc state, not established", d, 32'h81);
    be_established = 1'b1;
    do_rd(8'h00, d); check("R1", "loc state", d, 32'h80);
    do_rd(8'h0C, d); check("R1", "loc status", d, 32'h0);
    do_rd(8'h44, d); check("R1", "ctrl status", d, 32'h0);
    do_rd(8'h4C, d); check("R1", "start", d, 32'h0);
    do_rd(8'h30, d); check("R1", "iface", d, 32'h25811);
    check("R1", "be_req idle", {31'b0, be_req}, 32'h0);
    check("R1", "be_cancel idle", {31'b0, be_cancel}, 32'h0);

    // table of write/read pairs
    for (int i = 0; i < NVEC; i++) begin
      do_wr(VEC[i][83:76], VEC[i][75:44]);
      do_rd(VEC[i][43:36], d);
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("vector %0d", i), d, VEC[i][35:4]);
    end

    // R9 byte lanes
    do_rd(8'h31, d); check("R9", "iface byte 1", d, 32'h258);
    do_rd(8'h32, d); check("R9", "iface byte 2", d, 32'h2);
    do_rd(8'h5D, d); check("R9", "base byte 1", d, 32'hFED400);
    do_rd(8'h5F, d); check("R9", "base byte 3", d, 32'hFE);

    // R6 cancel while idle
    do_wr(8'h48, 32'h1);
    check("R6", "cancel idle", {31'b0, be_cancel}, 32'h0);
    // R5 wrong start value
    do_wr(8'h4C, 32'h2);
    check("R5", "start value 2", {31'b0, be_req}, 32'h0);

    // R5 / R8 header smallest
    cmd_hdr_size = 32'd100; be_capacity = 32'd5000;
    do_wr(8'h4C, 32'h1);
    check("R5", "req pulse", {31'b0, be_req}, 32'h1);
    check("R8", "len = header", be_cmd_len, 32'd100);
    @(negedge clk);
    check("R5", "req one cycle", {31'b0, be_req}, 32'h0);
    do_rd(8'h4C, d); check("R5", "start bit set", d, 32'h1);
    do_wr(8'h4C, 32'h1);
    check("R5", "start while busy", {31'b0, be_req}, 32'h0);
    do_wr(8'h48, 32'h2);
    check("R6", "cancel value 2", {31'b0, be_cancel}, 32'h0);
    do_wr(8'h48, 32'h1);
    check("R6", "cancel busy", {31'b0, be_cancel}, 32'h1);
    @(negedge clk);
    check("R6", "cancel one cycle", {31'b0, be_cancel}, 32'h0);
    finish_cmd(1'b0);
    do_rd(8'h4C, d); check("R7", "start cleared", d, 32'h0);
    do_rd(8'h44, d); check("R7", "no fatal", d, 32'h0);

    // R8 buffer smallest
    cmd_hdr_size = 32'd5000; be_capacity = 32'd10000;
    do_wr(8'h4C, 32'h1);
    check("R8", "len = buffer", be_cmd_len, 32'hF80);
    finish_cmd(1'b0);
    // R8 capacity smallest, completion with error
    cmd_hdr_size = 32'd5000; be_capacity = 32'd1000;
    do_wr(8'h4C, 32'h1);
    check("R8", "len = capacity", be_cmd_len, 32'd1000);
    finish_cmd(1'b1);
    do_rd(8'h44, d); check("R7", "fatal set", d, 32'h1);
    do_rd(8'h4C, d); check("R7", "start cleared on error", d, 32'h0);

    // R1 reset clears
    reset_dut();
    do_rd(8'h44, d); check("R1", "status after reset", d, 32'h0);
    do_rd(8'h0C, d); check("R1", "loc status after reset", d, 32'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule